// File: doc/BRIEF.md
# Double-Buffered Two-Channel DAC Code Controller

This block sits behind a two-wire bus slave receiver. Once the receiver has matched this device's address, it hands over each received byte with a one-cycle valid strobe. It also reports bus START and STOP events and a level telling whether this device is the current target. The block reads the bytes as alternating command and data bytes. Data goes into a per-channel staging register during a transmission. Nothing reaches the converter-facing outputs until a STOP ends the transmission.

Each channel has a staging (input) register and a live (output) register. One STOP copies every staging register to its live register in the same cycle, so both converters can change together. A power-down request is held pending and takes effect on the same STOP. A clear command empties the staging registers. Transmissions that are cut short by an early STOP, or that are abandoned by a repeated START to another device, follow fixed accept rules.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After reset every live code reads 0, every staging register holds 0 and `pdown` is 0.
- R2: The first byte after selection, and every second byte after that, is a command byte. In a command byte, bit 4 is the clear flag, bit 3 the power-down flag and bit 0 the channel select. Bits 7..5, 2 and 1 have no effect. The data byte that follows a command is written into the staging register of the channel picked by bit 0 (0 selects channel 0).
- R3: Live codes and `pdown` change only in the cycle after a STOP seen while `sel_active` is high. This happens only if at least one complete command byte arrived since the last START or STOP. Staging writes are not visible before that.
- R4: On such a STOP, every channel's live code takes its staging value in the same cycle.
- R5: At the committing STOP, `pdown` takes the power-down flag of the last complete command byte. Earlier command bytes in the same transmission have no effect on it.
- R6: A data byte that follows a command with the power-down flag set is still written, and it still reaches the live code at STOP.
- R7: A command with the clear flag set empties every staging register at once and discards the next data byte. Later command/data pairs in the same transmission write normally.
- R8: A STOP before a command byte completes drops that byte, and earlier complete pairs still commit. A transmission holding only an interrupted command leaves codes and `pdown` unchanged.
- R9: A STOP before a data byte completes drops the data. The clear and power-down flags of the preceding command still apply.
- R10: Staging data left behind when a repeated START selects another device stays pending. A STOP while `sel_active` is low commits nothing. The pending data is committed at the next selected transmission that has at least one complete command byte.
- R11: Bytes strobed while `sel_active` is low have no effect.
- R12: With `NUM_CH` = 1, the select bit is ignored and every data byte goes to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_byte_valid | input | 1 | One-cycle strobe: a complete byte is on `evt_byte` |
| evt_byte | input | 8 | Received byte |
| evt_start | input | 1 | One-cycle strobe: START or repeated START seen |
| evt_stop | input | 1 | One-cycle strobe: STOP seen |
| sel_active | input | 1 | High while this device is the addressed target |
| dac_code | output | NUM_CH x CODE_W | Live code per channel |
| pdown | output | 1 | Converters powered down |

## Verification
The bench sweeps all 256 command-byte values, each followed by a data byte, and compares the outputs with a transaction-level model. This would expose a decoder that read the clear, power-down or select flag from the wrong bit, or that reacted to a don't-care bit. A full code sweep on both channels catches a commit that updates only one channel, or that shows staging data before STOP. Directed cases cover the early-STOP rules, the byte that a clear command swallows, and the last-command-wins power-down rule. They also cover data stranded by a repeated START, which a faulty design would either commit under another device's STOP or lose. A second, single-channel instance checks that the select bit is forced to channel 0.

// File: rtl/dacpair_pkg.sv
package dacpair_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CLR_POS = 4;
    localparam int unsigned PD_POS  = 3;
    localparam int unsigned SEL_POS = 0;

    typedef struct packed {
        logic clr;
        logic pd;
        logic sel;
    } cmd_t;

    typedef struct packed {
        logic expect_data;
        logic have_cmd;
        logic skip_data;
        logic pend_pd;
        logic pend_sel;
        logic pd;
    } seq_t;
endpackage

// File: rtl/dpc_cmd_decode.sv
module dpc_cmd_decode
    import dacpair_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_t              fields
);
    always_comb begin
        fields.clr = cmd_byte[CLR_POS];
        fields.pd  = cmd_byte[PD_POS];
        fields.sel = (NUM_CH > 1) ? cmd_byte[SEL_POS] : 1'b0;
    end
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
    import dacpair_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              start,
    input  logic              stop,
    input  logic              addressed,
    input  cmd_t              cmd,
    output logic [NUM_CH-1:0] wr_en,
    output logic              clr_in,
    output logic              commit,
    output logic              pdown
);
    seq_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wr_en  = '0;
        clr_in = 1'b0;
        commit = 1'b0;
        if (stop) begin
            if (addressed && st_q.have_cmd) begin
                commit  = 1'b1;
                st_d.pd = st_q.pend_pd;
            end
            st_d.expect_data = 1'b0;
            st_d.have_cmd    = 1'b0;
            st_d.skip_data   = 1'b0;
        end else if (start) begin
            st_d.expect_data = 1'b0;
            st_d.have_cmd    = 1'b0;
            st_d.skip_data   = 1'b0;
        end else if (byte_valid && addressed) begin
            if (!st_q.expect_data) begin
                st_d.have_cmd    = 1'b1;
                st_d.pend_pd     = cmd.pd;
                st_d.pend_sel    = cmd.sel;
                st_d.skip_data   = cmd.clr;
                clr_in           = cmd.clr;
                st_d.expect_data = 1'b1;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    wr_en[i] = !st_q.skip_data && (32'(st_q.pend_sel) == i);
                end
                st_d.expect_data = 1'b0;
                st_d.skip_data   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pdown = st_q.pd;
endmodule

// File: rtl/dpc_chan.sv
module dpc_chan #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              clr,
    input  logic              commit,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] stage_d, stage_q;
    logic [CODE_W-1:0] live_d, live_q;

    always_comb begin
        stage_d = stage_q;
        live_d  = live_q;
        if (clr)     stage_d = '0;
        else if (wr) stage_d = din;
        if (commit)  live_d  = stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            stage_q <= stage_d;
            live_q  <= live_d;
        end
    end

    assign code = live_q;
endmodule

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
    import dacpair_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CODE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt_byte_valid,
    input  logic [7:0]                    evt_byte,
    input  logic                          evt_start,
    input  logic                          evt_stop,
    input  logic                          sel_active,
    output logic [NUM_CH-1:0][CODE_W-1:0] dac_code,
    output logic                          pdown
);
    cmd_t              fields;
    logic [NUM_CH-1:0] wr_en;
    logic              clr_in;
    logic              commit;

    dpc_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd_byte (evt_byte),
        .fields   (fields)
    );

    dpc_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (evt_byte_valid),
        .start      (evt_start),
        .stop       (evt_stop),
        .addressed  (sel_active),
        .cmd        (fields),
        .wr_en      (wr_en),
        .clr_in     (clr_in),
        .commit     (commit),
        .pdown      (pdown)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dpc_chan #(.CODE_W(CODE_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_en[g]),
            .clr    (clr_in),
            .commit (commit),
            .din    (evt_byte[CODE_W-1:0]),
            .code   (dac_code[g])
        );
    end
endmodule

// File: rtl/dac_pair_ctrl_chk.sv
module dac_pair_ctrl_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CODE_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          evt_stop,
    input logic                          sel_active,
    input logic [NUM_CH-1:0][CODE_W-1:0] dac_code,
    input logic                          pdown
);
    // R1: reset forces zero codes and normal power
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && !pdown));

    // R3: live codes move only right after a STOP
    p_code_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(evt_stop));

    // R5: power state moves only after a STOP while selected
    p_pd_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pdown) |-> $past(evt_stop && sel_active));

    // R10: a STOP while another device is targeted commits nothing
    p_foreign_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop && !sel_active) |=> ($stable(dac_code) && $stable(pdown)));
endmodule

bind dac_pair_ctrl dac_pair_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_stop   (evt_stop),
    .sel_active (sel_active),
    .dac_code   (dac_code),
    .pdown      (pdown)
);

// File: tb/dac_pair_ctrl_bench.sv
module dac_pair_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bv = 1'b0;
    logic [7:0] byt = '0;
    logic st = 1'b0;
    logic sp = 1'b0;
    logic sel = 1'b0;
    logic [1:0][7:0] code;
    logic pd;
    logic [0:0][7:0] code1;
    logic pd1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // transaction-level model derived from the requirements
    logic [7:0] m_in [2];
    logic [7:0] m_out [2];
    logic [7:0] m1_in, m1_out;
    logic m_pd, m_ppd, m_have, m_exp, m_skip, m_ch;

    always #10 clk = ~clk;

    dac_pair_ctrl u_dac_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_byte_valid(bv), .evt_byte(byt),
        .evt_start(st), .evt_stop(sp), .sel_active(sel),
        .dac_code(code), .pdown(pd)
    );

    dac_pair_ctrl #(.NUM_CH(1)) u_dac_pair_ctrl_one (
        .clk(clk), .rst_n(rst_n), .evt_byte_valid(bv), .evt_byte(byt),
        .evt_start(st), .evt_stop(sp), .sel_active(sel),
        .dac_code(code1), .pdown(pd1)
    );

    task automatic chk(input string tag);
        n_run++;
        if (code[0] !== m_out[0] || code[1] !== m_out[1] || pd !== m_pd ||
            code1[0] !== m1_out || pd1 !== m_pd) begin
            n_fail++;
            $display("FAIL %s: got ch0=%h ch1=%h pd=%b one=%h pd1=%b exp ch0=%h ch1=%h pd=%b one=%h",
                     tag, code[0], code[1], pd, code1[0], pd1, m_out[0], m_out[1], m_pd, m1_out);
        end
    endtask

    task automatic lit(input string tag, input logic [7:0] e0, input logic [7:0] e1, input logic ep);
        n_run++;
        if (code[0] !== e0 || code[1] !== e1 || pd !== ep) begin
            n_fail++;
            $display("FAIL %s: got %h %h %b exp %h %h %b", tag, code[0], code[1], pd, e0, e1, ep);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); bv = 1'b1; byt = b;
        @(negedge clk); bv = 1'b0;
        if (sel) begin
            if (!m_exp) begin
                m_have = 1'b1; m_ppd = b[3]; m_ch = b[0]; m_skip = b[4];
                if (b[4]) begin m_in[0] = '0; m_in[1] = '0; m1_in = '0; end
                m_exp = 1'b1;
            end else begin
                if (!m_skip) begin m_in[m_ch] = b; m1_in = b; end
                m_exp = 1'b0; m_skip = 1'b0;
            end
        end
    endtask

    task automatic stop_ev();
        @(negedge clk); sp = 1'b1;
        @(negedge clk); sp = 1'b0;
        if (sel && m_have) begin
            m_out[0] = m_in[0]; m_out[1] = m_in[1]; m1_out = m1_in; m_pd = m_ppd;
        end
        m_have = 1'b0; m_exp = 1'b0; m_skip = 1'b0;
    endtask

    task automatic start_ev(input logic s);
        @(negedge clk); st = 1'b1;
        @(negedge clk); st = 1'b0; sel = s;
        m_have = 1'b0; m_exp = 1'b0; m_skip = 1'b0;
    endtask

    initial begin
        m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
        m1_in = '0; m1_out = '0;
        m_pd = 0; m_ppd = 0; m_have = 0; m_exp = 0; m_skip = 0; m_ch = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lit("R1 reset", 8'h00, 8'h00, 1'b0);
        chk("R1 reset model");

        // R3: staged data invisible until STOP
        start_ev(1'b1);
        put(8'h00); put(8'h3C);
        chk("R3 before stop");
        stop_ev();
        lit("R3 after stop", 8'h3C, 8'h00, 1'b0);

        // R4: both channels commit together
        start_ev(1'b1);
        put(8'h01); put(8'h81); put(8'h00); put(8'h7E);
        lit("R4 held", 8'h3C, 8'h00, 1'b0);
        stop_ev();
        lit("R4 both", 8'h7E, 8'h81, 1'b0);

        // R2: don't-care bits ignored (E6 -> clr 0, pd 0, ch0)
        start_ev(1'b1);
        put(8'hE6); put(8'h4D);
        stop_ev();
        lit("R2 dont care", 8'h4D, 8'h81, 1'b0);

        // R5: lone power-down command, then last command wins
        start_ev(1'b1); put(8'h08); stop_ev();
        lit("R5 lone pd", 8'h4D, 8'h81, 1'b1);
        start_ev(1'b1);
        put(8'h08); put(8'h11); put(8'h01); put(8'h22);
        stop_ev();
        lit("R5 last clears pd", 8'h11, 8'h22, 1'b0);
        // R6: data with pd set still committed
        start_ev(1'b1);
        put(8'h00); put(8'h33); put(8'h09); put(8'h44);
        stop_ev();
        lit("R6 pd with data", 8'h33, 8'h44, 1'b1);

        // R7: clear discards next byte; later pair overwrites
        start_ev(1'b1);
        put(8'h10); put(8'hFF); put(8'h01); put(8'h5C);
        stop_ev();
        lit("R7 clear then pair", 8'h00, 8'h5C, 1'b0);
        start_ev(1'b1);
        put(8'h00); put(8'hAA); put(8'h10); put(8'hEE);
        stop_ev();
        lit("R7 clear discards", 8'h00, 8'h00, 1'b0);

        // R8: interrupted command dropped, prior pair commits
        start_ev(1'b1);
        put(8'h08); put(8'h66);
        stop_ev();
        lit("R8 mid command", 8'h66, 8'h00, 1'b1);
        start_ev(1'b1); stop_ev();
        lit("R8 lone interrupted", 8'h66, 8'h00, 1'b1);

        // R9: interrupted data dropped, flags still apply
        start_ev(1'b1); put(8'h01); stop_ev();
        lit("R9 pd off kept data", 8'h66, 8'h00, 1'b0);
        start_ev(1'b1); put(8'h00); put(8'h12); stop_ev();
        start_ev(1'b1); put(8'h19); stop_ev();
        lit("R9 clear applied", 8'h00, 8'h00, 1'b1);

        // R10 / R11: repeated start away, foreign bytes and STOP
        start_ev(1'b1);
        put(8'h00); put(8'h90); put(8'h01); put(8'h91);
        start_ev(1'b0);
        put(8'h00); put(8'hFF);
        stop_ev();
        lit("R10 foreign stop", 8'h00, 8'h00, 1'b1);
        start_ev(1'b1); put(8'h00); stop_ev();
        lit("R10 R11 pending commit", 8'h90, 8'h91, 1'b0);
        chk("R12 single channel");

        // R4 sweep of all codes on both channels
        for (int v = 0; v < 256; v++) begin
            start_ev(1'b1);
            put(8'h00); put(8'(v)); put(8'h01); put(8'(255 - v));
            stop_ev();
            chk("R4 code sweep");
        end

        // R2 R5 R7 R12 sweep of every command byte value
        for (int c = 0; c < 256; c++) begin
            start_ev(1'b1);
            put(8'(c)); put(8'(c) ^ 8'hA5);
            stop_ev();
            chk("R2 R5 R7 R12 command sweep");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule